// File: doc/BRIEF.md
# Constant-Delay Signed-Digit Adder

This block adds two redundant-binary numbers of M digits and returns their sum as one M-digit redundant-binary number. Each digit is carried on a pair of wires, one for a positive unit and one for a negative unit. This lets the sum be formed without a long carry chain. The block is the reduction cell of a multiplier's partial-product tree: two of its operands stand for four binary partial products, and its result stands for two.

Every digit position classifies the sum of its two input digits. It then makes an interim digit and an interim carry into the next position up. Where the digit sum is odd there are two possible interim pairs, and a flag from the position below chooses between them. The flag is set when either input digit at that lower position is negative. With this choice an interim digit and the carry arriving from below never add up to two, so the final digit needs no further carry. Each output digit therefore depends only on its own position and the two positions beneath it, whatever M is.

The block has no clock and no storage. A carry out of the top digit is dropped, so the result equals the true sum modulo 2^M.

Top module: `rb_carry_limited_adder`

## Requirements
- R1: A digit pair (pos,neg) encodes (1,0)=+1, (0,0)=0 and (0,1)=-1, and digit i has weight 2^i. For legal operands, the value of the output equals value(x)+value(y) modulo 2^M.
- R2: When no input digit is (1,1), no output digit is (1,1).
- R3: A position whose two input digits sum to 0 makes neither an interim digit nor a carry. Operands that are digit-wise negatives of each other give an all-zero output.
- R4: Two +1 digits at position i carry +1 into position i+1 and leave 0 at i. Two -1 digits carry -1 and leave 0 at i.
- R5: A digit sum of -1 at position i, with no negative input digit at i-1, gives output -1 at i and no carry. With a negative input digit at i-1, it gives interim +1 at i and carries -1 into i+1.
- R6: A digit sum of +1 at position i, with no negative input digit at i-1, gives interim -1 at i and carries +1 into i+1. With a negative input digit (in either operand) at i-1, it gives +1 at i and no carry.
- R7: Each output digit is its interim digit plus the carry from the position below, re-encoded into the legal form.
- R8: Digit 0 sees no negative flag and no carry from below, so an odd sum there gives -1 at digit 0 and an even sum gives 0. A carry out of digit M-1 is discarded.
- R9: The output follows the inputs combinationally, with no clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| x_pos | input | M | Positive-unit bits of operand x |
| x_neg | input | M | Negative-unit bits of operand x |
| y_pos | input | M | Positive-unit bits of operand y |
| y_neg | input | M | Negative-unit bits of operand y |
| s_pos | output | M | Positive-unit bits of the sum |
| s_neg | output | M | Negative-unit bits of the sum |

## Verification
The bench aims at the two odd-sum cases, both with and without a negative digit just below. It also places that lower negative digit in the opposite operand from the odd digit. A flag taken from the wrong operand, or from the wrong position, would give a wrong sum there, or would make an interim +1 meet a +1 carry and produce an illegal (1,1) digit. It drives a double digit into the top position, where a carry that wrapped around instead of being dropped would corrupt digit 0. It also drives a double digit into digit 0, where a stray flag from below would flip the result. Random legal vectors are compared by value modulo 2^M against a behavioural sum, and every output digit is checked for legality.

// File: rtl/rb_pkg.sv
package rb_pkg;
  // Signed digit value carried between pieces of logic: -2..+2 fits in 3 bits
  typedef logic signed [2:0] sdig_t;

  // Decode a legal (pos,neg) pair into a signed digit
  function automatic sdig_t pair_to_int(input logic p, input logic n);
    sdig_t v;
    v = 3'sd0;
    if (p && !n) v = 3'sd1;
    else if (n && !p) v = -3'sd1;
    return v;
  endfunction

  // Encode a digit known to be -1, 0 or +1 back into a pair
  function automatic logic [1:0] int_to_pair(input sdig_t v);
    logic [1:0] pn;
    pn = 2'b00;
    if (v == 3'sd1) pn = 2'b10;
    else if (v == -3'sd1) pn = 2'b01;
    return pn;
  endfunction
endpackage

// File: rtl/rb_digit_stage.sv
module rb_digit_stage
  import rb_pkg::*;
(
  input  logic  xp,
  input  logic  xn,
  input  logic  yp,
  input  logic  yn,
  input  logic  neg_below,
  output sdig_t interim,
  output sdig_t carry
);
  sdig_t dsum;

  always_comb begin
    dsum    = pair_to_int(xp, xn) + pair_to_int(yp, yn);
    interim = 3'sd0;
    carry   = 3'sd0;
    case (dsum)
      3'sd2:  carry = 3'sd1;
      -3'sd2: carry = -3'sd1;
      3'sd1: begin
        if (neg_below) begin
          interim = 3'sd1;
        end else begin
          interim = -3'sd1;
          carry   = 3'sd1;
        end
      end
      -3'sd1: begin
        if (neg_below) begin
          interim = 3'sd1;
          carry   = -3'sd1;
        end else begin
          interim = -3'sd1;
        end
      end
      default: begin
        interim = 3'sd0;
        carry   = 3'sd0;
      end
    endcase
  end
endmodule

// File: rtl/rb_digit_merge.sv
module rb_digit_merge
  import rb_pkg::*;
(
  input  sdig_t interim,
  input  sdig_t carry_below,
  output logic  sp,
  output logic  sn
);
  sdig_t total;

  always_comb begin
    total    = interim + carry_below;
    {sp, sn} = int_to_pair(total);
  end
endmodule

// File: rtl/rb_carry_limited_adder.sv
module rb_carry_limited_adder
  import rb_pkg::*;
#(
  parameter int M = 16
) (
  input  logic [M-1:0] x_pos,
  input  logic [M-1:0] x_neg,
  input  logic [M-1:0] y_pos,
  input  logic [M-1:0] y_neg,
  output logic [M-1:0] s_pos,
  output logic [M-1:0] s_neg
);
  localparam int NFLAG = M + 1;

  // flag[i] describes position i-1; flag[0] is the virtual position below digit 0
  logic [NFLAG-1:0] flag;
  sdig_t            interim [M];
  sdig_t            carry   [NFLAG];

  assign flag[0]  = 1'b0;
  assign carry[0] = 3'sd0;

  for (genvar i = 0; i < M; i++) begin : g_digit
    assign flag[i+1] = x_neg[i] | y_neg[i];

    rb_digit_stage u_stage (
      .xp        (x_pos[i]),
      .xn        (x_neg[i]),
      .yp        (y_pos[i]),
      .yn        (y_neg[i]),
      .neg_below (flag[i]),
      .interim   (interim[i]),
      .carry     (carry[i+1])
    );

    rb_digit_merge u_merge (
      .interim     (interim[i]),
      .carry_below (carry[i]),
      .sp          (s_pos[i]),
      .sn          (s_neg[i])
    );
  end
  // carry[M] leaves the top digit and is dropped
endmodule

// File: rtl/rb_adder_checker.sv
module rb_adder_checker #(
  parameter int M = 16
) (
  input logic [M-1:0] x_pos,
  input logic [M-1:0] x_neg,
  input logic [M-1:0] y_pos,
  input logic [M-1:0] y_neg,
  input logic [M-1:0] s_pos,
  input logic [M-1:0] s_neg
);
  logic known;
  logic legal;

  always_comb begin
    known = !$isunknown({x_pos, x_neg, y_pos, y_neg, s_pos, s_neg});
    legal = known && ((x_pos & x_neg) == '0) && ((y_pos & y_neg) == '0);

    if (legal) begin
      p_out_legal_r2: assert ((s_pos & s_neg) == '0)
        else $error("R2: illegal output digit");
      p_cancel_zero_r3: assert (!((x_pos == y_neg) && (x_neg == y_pos))
                                || (s_pos == '0 && s_neg == '0))
        else $error("R3: cancelling operands gave nonzero sum");
      p_zero_in_r1: assert (({x_pos, x_neg, y_pos, y_neg} != '0)
                            || (s_pos == '0 && s_neg == '0))
        else $error("R1: zero operands gave nonzero sum");
      p_lsb_digit_r8: assert (((x_pos[0] | x_neg[0]) ^ (y_pos[0] | y_neg[0]))
                              ? (s_neg[0] && !s_pos[0])
                              : (!s_neg[0] && !s_pos[0]))
        else $error("R8: digit 0 wrong");
    end
  end
endmodule

bind rb_carry_limited_adder rb_adder_checker #(.M(M)) u_chk (
  .x_pos (x_pos),
  .x_neg (x_neg),
  .y_pos (y_pos),
  .y_neg (y_neg),
  .s_pos (s_pos),
  .s_neg (s_neg)
);

// File: tb/rb_carry_limited_adder_test.sv
module rb_carry_limited_adder_test;
  localparam int M = 16;
  localparam longint MASK = (64'sd1 <<< M) - 1;

  logic clk;
  logic rst_n;
  logic [M-1:0] x_pos, x_neg, y_pos, y_neg, s_pos, s_neg;
  int n_checks;
  int n_fails;
  bit finished;

  rb_carry_limited_adder #(.M(M)) uut (
    .x_pos (x_pos),
    .x_neg (x_neg),
    .y_pos (y_pos),
    .y_neg (y_neg),
    .s_pos (s_pos),
    .s_neg (s_neg)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  function automatic longint rb_value(input logic [M-1:0] p, input logic [M-1:0] n);
    longint v;
    v = 0;
    for (int i = 0; i < M; i++) begin
      if (p[i]) v += (64'sd1 <<< i);
      if (n[i]) v -= (64'sd1 <<< i);
    end
    return v;
  endfunction

  task automatic drive(input logic [M-1:0] xp, input logic [M-1:0] xn,
                       input logic [M-1:0] yp, input logic [M-1:0] yn);
    @(posedge clk);
    #1 {x_pos, x_neg, y_pos, y_neg} = {xp, xn, yp, yn};
    @(negedge clk);
  endtask

  task automatic check_value(input string req);
    longint diff;
    diff = (rb_value(s_pos, s_neg) - rb_value(x_pos, x_neg) - rb_value(y_pos, y_neg)) & MASK;
    n_checks++;
    if (diff != 0 || (s_pos & s_neg) != '0) begin
      n_fails++;
      $display("FAIL %s: sum value %0d (pos %h neg %h), expected %0d mod 2^%0d, no (1,1)",
               req, rb_value(s_pos, s_neg), s_pos, s_neg,
               rb_value(x_pos, x_neg) + rb_value(y_pos, y_neg), M);
    end
  endtask

  task automatic check_exact(input string req, input logic [M-1:0] ep, input logic [M-1:0] en);
    n_checks++;
    if (s_pos !== ep || s_neg !== en) begin
      n_fails++;
      $display("FAIL %s: got pos %h neg %h, expected pos %h neg %h", req, s_pos, s_neg, ep, en);
    end
  endtask

  function automatic logic [1:0] rand_digit();
    int r;
    r = $urandom_range(2);
    return (r == 1) ? 2'b10 : (r == 2) ? 2'b01 : 2'b00;
  endfunction

  initial begin
    n_checks = 0;
    n_fails  = 0;
    finished = 0;
    rst_n    = 1'b0;
    {x_pos, x_neg, y_pos, y_neg} = '0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;

    // R1 zero operands
    drive('0, '0, '0, '0);
    check_exact("R1 zero", '0, '0);

    // R4 double digits
    drive(16'h0020, '0, 16'h0020, '0);
    check_exact("R4 both +1", 16'h0040, '0);
    drive('0, 16'h0020, '0, 16'h0020);
    check_exact("R4 both -1", '0, 16'h0040);

    // R8 top carry dropped, digit 0 cases
    drive(16'h8000, '0, 16'h8000, '0);
    check_exact("R8 top overflow", '0, '0);
    drive('0, 16'h8000, '0, 16'h8000);
    check_exact("R8 top underflow", '0, '0);
    drive(16'h0001, '0, '0, '0);
    check_exact("R8 digit0 odd", 16'h0002, 16'h0001);
    drive('0, 16'h0001, '0, 16'h0001);
    check_exact("R8 digit0 even", '0, 16'h0002);

    // R5 sum -1
    drive('0, 16'h0020, '0, '0);
    check_exact("R5 no flag", '0, 16'h0020);
    drive('0, 16'h0030, '0, '0);
    check_exact("R5 flag set", 16'h0020, 16'h0050);

    // R6 sum +1
    drive(16'h0020, '0, '0, '0);
    check_exact("R6 no flag", 16'h0040, 16'h0020);
    drive(16'h0020, 16'h0010, '0, '0);
    check_exact("R6 flag same operand", 16'h0020, 16'h0010);
    drive(16'h0020, '0, '0, 16'h0010);
    check_exact("R6 flag other operand", 16'h0020, 16'h0010);

    // R7 mixed interim and carry
    drive(16'h00F0, 16'h000F, 16'h0F00, 16'h0008);
    check_value("R7 mixed");

    // R3 cancelling operands
    for (int k = 0; k < 20; k++) begin
      logic [M-1:0] p, n;
      for (int i = 0; i < M; i++) {p[i], n[i]} = rand_digit();
      drive(p, n, n, p);
      check_exact("R3 cancel", '0, '0);
    end

    // R9 output follows inputs without a clock edge
    {x_pos, x_neg, y_pos, y_neg} = {16'h0004, 16'h0000, 16'h0004, 16'h0000};
    #1;
    check_exact("R9 combinational", 16'h0008, '0);

    // R1 R2 random legal vectors
    for (int k = 0; k < 3000; k++) begin
      logic [M-1:0] xp, xn, yp, yn;
      for (int i = 0; i < M; i++) begin
        {xp[i], xn[i]} = rand_digit();
        {yp[i], yn[i]} = rand_digit();
      end
      drive(xp, xn, yp, yn);
      check_value("R1 R2 random");
    end

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end

  initial begin
    #(5.0 * 200000);
    if (!finished) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: run did not end, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
      $finish;
    end
  end
endmodule